// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM, one 4-bit word wide. The host raises a request with a direction flag, an address and write data. The block captures these values in the same cycle and drives the memory's select, write and output-enable strobes in the correct order. Each pulse and wait lasts a whole number of clock cycles. That count is set by a parameter, found by dividing the memory's nanosecond minimum by the clock period and rounding up.

Reads hold select and output enable low until the access time has passed, then register the returned nibble. Writes hold output enable high for the whole operation, so the shortest write pulse is permitted. Data is driven one cycle before the write strobe falls and kept for one cycle after it rises. Every operation ends with a turnaround phase with the memory deselected and the block's own drivers off. This covers the time the memory's output drivers take to release the bus. A one-cycle completion pulse then follows.

The strobes are taken directly from state-register bits, so they cannot glitch.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is active and in the first idle cycle after it, the block holds mem_cs_n, mem_we_n and mem_oe_n at 1, and holds mem_dq_oe, busy and done at 0.
- R2: A read drives mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly RD_WAIT cycles, starting in the cycle after acceptance.
- R3: The read nibble is sampled from mem_dq_in at the clock edge that ends the last read-wait cycle. It appears on rdata in the cycle in which done is high.
- R4: A write drives one setup cycle with select low and write enable high. Next come WR_PULSE cycles with both select and write enable low. Last comes one hold cycle with select low and write enable high. mem_oe_n stays 1 for the whole write.
- R5: mem_dq_oe is 1 from the write setup cycle through the hold cycle, and mem_dq_out equals the captured write data during that whole span.
- R6: Every read or write ends with TURN cycles in which mem_cs_n=1 and mem_dq_oe=0. The data drivers are never enabled while output enable is low, or in the cycle directly after it was low.
- R7: busy is 1 from the cycle after acceptance through the last turnaround cycle. done is a single-cycle pulse in the first idle cycle that follows. A request raised while busy is 1 is ignored and does not start a new operation.
- R8: mem_addr holds the address captured at acceptance for the whole operation, whatever happens on addr and wdata after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; accepted when the block is idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Host address |
| wdata | input | DW | Host write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last read data |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DW | Data to memory |
| mem_dq_in | input | DW | Data from memory |
| mem_dq_oe | output | 1 | Enable for the block's data drivers |

## Verification
The hardest case to produce from the ports is a read sampled too early. A simple memory model would return correct data at any moment and hide the fault. The bench model therefore returns the inverted nibble until select and output enable have both been low for the full read-wait count, so a read sampled one edge early fails the data comparison. A second hard case is a request arriving while busy. The bench raises such requests and scrambles addr and wdata on every busy cycle, then confirms that the strobes and busy stay idle once the operation has completed.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW       = 20,
  parameter int DW       = 4,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 1,
  parameter int TURN     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int MAXC = (RD_WAIT > WR_PULSE) ? ((RD_WAIT > TURN) ? RD_WAIT : TURN)
                                             : ((WR_PULSE > TURN) ? WR_PULSE : TURN);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  // bits: {tag, cs_n, we_n, oe_n, drive}
  typedef enum logic [4:0] {
    S_IDLE = 5'b01110,
    S_TURN = 5'b11110,
    S_READ = 5'b00100,
    S_WSET = 5'b00111,
    S_WPUL = 5'b00011,
    S_WHLD = 5'b10111
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  assign mem_cs_n   = st[3];
  assign mem_we_n   = st[2];
  assign mem_oe_n   = st[1];
  assign mem_dq_oe  = st[0];
  assign busy       = (st != S_IDLE);
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          a_q <= addr;
          d_q <= wdata;
          cnt <= CW'(RD_WAIT - 1);
          st  <= wr ? S_WSET : S_READ;
        end
        S_READ: if (cnt == '0) begin
          rdata <= mem_dq_in;
          cnt   <= CW'(TURN - 1);
          st    <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_WSET: begin
          cnt <= CW'(WR_PULSE - 1);
          st  <= S_WPUL;
        end
        S_WPUL: if (cnt == '0) st <= S_WHLD;
                else cnt <= cnt - 1'b1;
        S_WHLD: begin
          cnt <= CW'(TURN - 1);
          st  <= S_TURN;
        end
        S_TURN: if (cnt == '0) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));

  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

  a_r6_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_cs_n)));

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  localparam int AW = 4, DW = 4, RDW = 3, WPW = 2, TRN = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req, wr, busy, done, cs_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] addr, mem_addr;
  logic [DW-1:0] wdata, rdata, dq_out, dq_in;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .RD_WAIT(RDW), .WR_PULSE(WPW), .TURN(TRN)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n),
    .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe));

  logic [DW-1:0] mem [16];
  int age = 0;
  always @(posedge clk) begin
    if (!cs_n && !we_n) mem[mem_addr] <= dq_out;
    if (!cs_n && !oe_n) age <= age + 1;
    else                age <= 0;
  end
  assign dq_in = (!cs_n && !oe_n && age >= RDW - 1) ? mem[mem_addr] : ~mem[mem_addr];

  int checks = 0, fails = 0;
  logic [DW-1:0] shadow [16];

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic op(bit w, logic [3:0] a, logic [3:0] d, logic [3:0] exp_rd);
    int n;
    logic [3:0] e;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    n = w ? 2 + WPW + TRN : RDW + TRN;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      req = i[0]; addr = ~a; wdata = ~d; wr = ~w;
      chk("R7 busy during op", {7'd0, busy}, 8'd1);
      chk("R8 address held", {4'd0, mem_addr}, {4'd0, a});
      if (w) begin
        if (i == 1)              e = 4'b0111;
        else if (i <= 1 + WPW)   e = 4'b0011;
        else if (i == 2 + WPW)   e = 4'b0111;
        else                     e = 4'b1110;
        chk(i > 2 + WPW ? "R6 write turnaround" : "R4 write strobes",
            {4'd0, cs_n, we_n, oe_n, dq_oe}, {4'd0, e});
        if (dq_oe) chk("R5 write data", {4'd0, dq_out}, {4'd0, d});
      end else begin
        e = (i <= RDW) ? 4'b0100 : 4'b1110;
        chk(i > RDW ? "R6 read turnaround" : "R2 read strobes",
            {4'd0, cs_n, we_n, oe_n, dq_oe}, {4'd0, e});
      end
    end
    @(negedge clk);
    req = 1'b0;
    chk("R7 done pulse", {6'd0, done, busy}, 8'b10);
    if (!w) chk("R3 read data", {4'd0, rdata}, {4'd0, exp_rd});
    @(negedge clk);
    chk("R7 ignored request", {5'd0, done, busy, cs_n}, 8'b001);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {4'd0, cs_n, we_n, oe_n, dq_oe}, 8'b1110);
    chk("R1 reset handshake", {6'd0, busy, done}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {3'd0, cs_n, we_n, oe_n, dq_oe, busy}, 8'b11100);
    for (int a = 0; a < 16; a++) begin
      shadow[a] = 4'((a * 7 + 3) & 15);
      op(1'b1, 4'(a), shadow[a], 4'd0);
    end
    for (int a = 0; a < 16; a++) op(1'b0, 4'(a), 4'(a), shadow[a]);
    for (int a = 0; a < 16; a += 2) begin
      shadow[a] = ~shadow[a];
      op(1'b1, 4'(a), shadow[a], 4'd0);
    end
    for (int a = 15; a >= 0; a--) op(1'b0, 4'(a), ~4'(a), shadow[a]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule